// File: doc/BRIEF.md
# Reset-Time Strap Capture with Status LED Drive

This block reads a set of board-level configuration straps while the chip is held in hardware or power-on reset, and keeps their values for the rest of operation. Nine pads are involved. Five of them are dual-use. During reset they are inputs whose levels form the 5-bit management address. After reset they become status LED drivers. The other four pads carry the link-speed, duplex, auto-negotiation and MAC-interface-mode straps.

All pad levels pass through a two-flop synchronizer. Reset release is retimed by a two-stage release sequencer. The capture registers follow the synchronized pads for as long as the sequencer's release signal is low, and they freeze on the clock edge where it goes high. That edge is the latching edge. On the next edge the five LED pads are enabled as outputs.

Each LED output is its status input XORed with that pad's own captured strap bit. A pad strapped low therefore lights its LED with a high level. A pad strapped high lights it with a low level. While reset is asserted, all LED pads are left undriven, so the external strap resistors alone set their levels.

All pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `strap_led_ctrl`

## Requirements
- R1: `phy_addr` equals the levels on `pad_addr_in` that were held stable for at least three clock edges before `rst_n` rose. It is valid from the second rising clock edge after the release.
- R2: `cfg_speed_100` takes the captured level of `pad_speed_in`. A 1 means 100 Mbps.
- R3: `cfg_full_duplex` takes the captured level of `pad_duplex_in`. A 1 means full duplex.
- R4: `cfg_aneg_en` takes the captured level of `pad_aneg_in`. A 1 enables auto-negotiation and a 0 means forced mode.
- R5: `cfg_mii_mode` takes the captured level of `pad_mode_in`. A 1 selects MII and a 0 selects the serial interface mode.
- R6: Once captured, no captured value changes when the pads change. Captured values change only through a new reset.
- R7: While `rst_n` is low, every bit of `pad_oe` and `pad_out` is 0. This takes effect without waiting for a clock edge.
- R8: All bits of `pad_oe` rise together at the third rising edge after release, which is one edge after the latching edge.
- R9: While enabled, `pad_out[i]` equals `led_status[i]` sampled at the previous rising edge, XORed with `phy_addr[i]`. A strap bit of 0 gives active-high drive and a strap bit of 1 gives active-low drive. While not enabled, `pad_out` is 0.
- R10: A second reset followed by a release captures the pad levels present at that new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware/power-on reset |
| pad_addr_in | input | 5 | Input levels of the dual-use address/LED pads |
| pad_speed_in | input | 1 | Speed strap pad level |
| pad_duplex_in | input | 1 | Duplex strap pad level |
| pad_aneg_in | input | 1 | Auto-negotiation strap pad level |
| pad_mode_in | input | 1 | MAC interface mode strap pad level |
| led_status | input | 5 | Active-high status for each LED (link, activity, etc.) |
| phy_addr | output | 5 | Captured management address |
| cfg_speed_100 | output | 1 | Captured speed strap |
| cfg_full_duplex | output | 1 | Captured duplex strap |
| cfg_aneg_en | output | 1 | Captured auto-negotiation strap |
| cfg_mii_mode | output | 1 | Captured interface mode strap |
| pad_oe | output | 5 | Output enable for each dual-use pad |
| pad_out | output | 5 | Output level for each dual-use pad |

## Verification
Counting rising edges from the release of `rst_n`, the captured address and straps are due at edge two and the output enables at edge three. From edge three on, each LED level follows its status input one edge later. Reset assertion clears the enables and LED levels at once, with no edge needed. The bench keeps a count of edges since release and a copy of the status input from the last edge. It compares every output at each falling edge against the value that count and copy imply. Stimulus changes only after that comparison, so each check sits midway between the edge that sets a value and the edge that could change it.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  parameter int unsigned LED_PADS = 5;

  typedef struct packed {
    logic speed_100;
    logic full_duplex;
    logic aneg_en;
    logic mii_mode;
  } strap_cfg_t;

  parameter int unsigned CFG_BITS = $bits(strap_cfg_t);
endpackage

// File: rtl/strap_sync.sv
// Multi-stage synchronizer for pad levels; intentionally not reset so it
// keeps sampling while the chip is held in reset.
module strap_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/reset_release_seq.sv
// Retimes reset release: 'go' marks the latching edge, 'run' follows one edge later.
module reset_release_seq #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic capture_en,
  output logic go,
  output logic run
);
  logic [STAGES-1:0] rel_q;
  logic              run_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rel_q <= '0;
      else        rel_q <= 1'b1;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rel_q <= '0;
      else        rel_q <= {rel_q[STAGES-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= rel_q[STAGES-1];
  end

  assign go         = rel_q[STAGES-1];
  assign capture_en = ~rel_q[STAGES-1];
  assign run        = run_q;
endmodule

// File: rtl/strap_capture.sv
// Holds strap values; tracks the synchronized pads until capture closes.
module strap_capture #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             capture_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (capture_en) hold_q <= d;
  end

  assign q = hold_q;
endmodule

// File: rtl/led_drive.sv
// Per-pad LED driver with polarity taken from the pad's own strap bit.
module led_drive #(
  parameter int unsigned PADS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            run,
  input  logic [PADS-1:0] status,
  input  logic [PADS-1:0] polarity,
  output logic [PADS-1:0] oe,
  output logic [PADS-1:0] level
);
  for (genvar i = 0; i < PADS; i++) begin : g_pad
    logic lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lvl_q <= 1'b0;
      else if (go) lvl_q <= status[i] ^ polarity[i];
      else         lvl_q <= 1'b0;
    end
    assign level[i] = lvl_q;
    assign oe[i]    = run;
  end
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
#(
  parameter int unsigned NPADS       = LED_PADS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REL_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPADS-1:0] pad_addr_in,
  input  logic             pad_speed_in,
  input  logic             pad_duplex_in,
  input  logic             pad_aneg_in,
  input  logic             pad_mode_in,
  input  logic [NPADS-1:0] led_status,
  output logic [NPADS-1:0] phy_addr,
  output logic             cfg_speed_100,
  output logic             cfg_full_duplex,
  output logic             cfg_aneg_en,
  output logic             cfg_mii_mode,
  output logic [NPADS-1:0] pad_oe,
  output logic [NPADS-1:0] pad_out
);
  localparam int unsigned ALL_BITS = NPADS + CFG_BITS;

  strap_cfg_t            raw_cfg, held_cfg;
  logic [ALL_BITS-1:0]   raw_bus, sync_bus, held_bus;
  logic                  capture_en, go, run;
  logic [NPADS-1:0]      held_addr;

  assign raw_cfg = '{speed_100:   pad_speed_in,
                     full_duplex: pad_duplex_in,
                     aneg_en:     pad_aneg_in,
                     mii_mode:    pad_mode_in};
  assign raw_bus = {raw_cfg, pad_addr_in};

  strap_sync #(.WIDTH(ALL_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  reset_release_seq #(.STAGES(REL_STAGES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .go         (go),
    .run        (run)
  );

  strap_capture #(.WIDTH(ALL_BITS)) u_cap (
    .clk        (clk),
    .capture_en (capture_en),
    .d          (sync_bus),
    .q          (held_bus)
  );

  assign held_addr = held_bus[NPADS-1:0];
  assign held_cfg  = strap_cfg_t'(held_bus[ALL_BITS-1:NPADS]);

  led_drive #(.PADS(NPADS)) u_led (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .run      (run),
    .status   (led_status),
    .polarity (held_addr),
    .oe       (pad_oe),
    .level    (pad_out)
  );

  assign phy_addr        = held_addr;
  assign cfg_speed_100   = held_cfg.speed_100;
  assign cfg_full_duplex = held_cfg.full_duplex;
  assign cfg_aneg_en     = held_cfg.aneg_en;
  assign cfg_mii_mode    = held_cfg.mii_mode;
endmodule

// File: rtl/strap_led_ctrl_chk.sv
module strap_led_ctrl_chk #(
  parameter int unsigned NPADS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPADS-1:0] led_status,
  input logic [NPADS-1:0] phy_addr,
  input logic             cfg_speed_100,
  input logic             cfg_full_duplex,
  input logic             cfg_aneg_en,
  input logic             cfg_mii_mode,
  input logic [NPADS-1:0] pad_oe,
  input logic [NPADS-1:0] pad_out
);
  // R7: pads released to the strap resistors whenever reset is low
  p_oe_off_in_reset_r7: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0));

  // R8: enables move as one group
  p_oe_grouped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == '0) || (pad_oe == '1));

  // R6: captured values frozen while pads are driven
  p_straps_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[0] |-> ($stable(phy_addr) && $stable(cfg_speed_100) &&
                   $stable(cfg_full_duplex) && $stable(cfg_aneg_en) &&
                   $stable(cfg_mii_mode)));

  // R8: address already settled when enables rise
  p_latched_before_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe[0]) |-> $stable(phy_addr));

  // R9: LED level follows prior status with per-pad polarity
  p_led_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[0] |-> (pad_out == ($past(led_status) ^ phy_addr)));

  // R9: no LED level while not enabled
  p_led_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe[0] |-> (pad_out == '0));
endmodule

bind strap_led_ctrl strap_led_ctrl_chk #(.NPADS(NPADS)) u_chk (.*);

// File: tb/strap_led_ctrl_test.sv
module strap_led_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pad_addr_in = '0;
  logic       pad_speed_in = 1'b0, pad_duplex_in = 1'b0;
  logic       pad_aneg_in = 1'b0, pad_mode_in = 1'b0;
  logic [4:0] led_status = '0;
  logic [4:0] phy_addr, pad_oe, pad_out;
  logic       cfg_speed_100, cfg_full_duplex, cfg_aneg_en, cfg_mii_mode;

  int checks = 0, failures = 0;
  int edges_since_rel = 0;
  int round = 0;
  bit pads_moved = 0;
  logic [4:0] last_status = '0;
  logic [4:0] exp_addr = '0;
  logic [3:0] exp_cfg = '0;   // {speed, duplex, aneg, mode}

  always #2 clk = ~clk;   // 250 MHz

  strap_led_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pad_addr_in(pad_addr_in),
    .pad_speed_in(pad_speed_in), .pad_duplex_in(pad_duplex_in),
    .pad_aneg_in(pad_aneg_in), .pad_mode_in(pad_mode_in),
    .led_status(led_status), .phy_addr(phy_addr),
    .cfg_speed_100(cfg_speed_100), .cfg_full_duplex(cfg_full_duplex),
    .cfg_aneg_en(cfg_aneg_en), .cfg_mii_mode(cfg_mii_mode),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: edge count since release and last sampled status
  always @(posedge clk) begin
    if (!rst_n) edges_since_rel = 0;
    else if (edges_since_rel < 1000) edges_since_rel++;
    last_status = led_status;
  end
  always @(negedge rst_n) edges_since_rel = 0;
  always @(posedge rst_n) begin
    exp_addr = pad_addr_in;
    exp_cfg  = {pad_speed_in, pad_duplex_in, pad_aneg_in, pad_mode_in};
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R7 oe", pad_oe, 5'b0);
      check("R7 out", pad_out, 5'b0);
    end else begin
      if (edges_since_rel >= 2) begin
        if (round == 2)      check("R10 addr", phy_addr, exp_addr);
        else if (pads_moved) check("R6 addr", phy_addr, exp_addr);
        else                 check("R1 addr", phy_addr, exp_addr);
        check("R2 speed",  {4'b0, cfg_speed_100},   {4'b0, exp_cfg[3]});
        check("R3 duplex", {4'b0, cfg_full_duplex}, {4'b0, exp_cfg[2]});
        check("R4 aneg",   {4'b0, cfg_aneg_en},     {4'b0, exp_cfg[1]});
        check("R5 mode",   {4'b0, cfg_mii_mode},    {4'b0, exp_cfg[0]});
        if (pads_moved)
          check("R6 cfg", {1'b0, cfg_speed_100, cfg_full_duplex, cfg_aneg_en, cfg_mii_mode},
                {1'b0, exp_cfg});
      end
      check("R8 oe", pad_oe, (edges_since_rel >= 3) ? 5'b11111 : 5'b00000);
      check("R9 out", pad_out, (edges_since_rel >= 3) ? (last_status ^ exp_addr) : 5'b00000);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    fork
      begin
        #400000;
        failures++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    // Round 1: mixed straps
    round = 1;
    pad_addr_in = 5'b10110;
    {pad_speed_in, pad_duplex_in, pad_aneg_in, pad_mode_in} = 4'b1011;
    led_status = 5'b00111;
    step(6);
    rst_n = 1'b1;
    led_status = 5'b11000;
    step(4);
    for (int k = 0; k < 8; k++) begin
      led_status = 5'(k * 7 + 3);
      step(1);
    end
    // R6: pads move after capture
    pads_moved = 1;
    pad_addr_in = 5'b01001;
    {pad_speed_in, pad_duplex_in, pad_aneg_in, pad_mode_in} = 4'b0100;
    led_status = 5'b11111;
    step(5);
    led_status = 5'b00000;
    step(3);

    // Round 2 (R10): reset mid-cycle, new straps
    #0.5 rst_n = 1'b0;
    pads_moved = 0;
    round = 2;
    pad_addr_in = 5'b01001;
    {pad_speed_in, pad_duplex_in, pad_aneg_in, pad_mode_in} = 4'b0100;
    step(5);
    rst_n = 1'b1;
    step(4);
    for (int k = 0; k < 5; k++) begin
      led_status = 5'b00001 << k;
      step(1);
    end
    led_status = 5'b11111;
    step(2);
    led_status = 5'b00000;
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule